// File: doc/BRIEF.md
# Management Data Serial Command Controller

This block places one 32-bit command/status register in front of a serial management master for external transceivers. Software writes the register once with a transceiver address, an internal register address, a direction bit and, for writes, sixteen bits of data. The block then sends the complete management frame on a divided clock and a bidirectional data line. On a read it releases the data line, shifts in the sixteen bits that come back, and places them in the low half of the same register.

Software learns the state of the block by polling two flags in the register. A busy flag covers the whole frame. A read-valid flag says that the low half now holds returned data. A write that arrives while busy is dropped. The data line is split into a driven value, an output enable and a sampled input, so that the pad can be built outside the block.

Top module: `mdio_cmd_ctl`

## Requirements
- R1: Register layout. Bits 15:0 hold data, 20:16 the 5-bit transceiver address, 25:21 the 5-bit register address, and 26 the direction (1 = read, 0 = write). Bit 27 is read-valid, bit 28 is busy, and bits 31:29 read as zero. After an accepted write, bits 26:16 read back as written. After a write frame, bits 15:0 read back as written.
- R2: Every frame starts with 32 bits of one. These are followed by the start pattern 0 then 1.
- R3: After the start pattern come two opcode bits: 1,0 for a read and 0,1 for a write. Then come the 5-bit transceiver address and the 5-bit register address, each MSB first. This makes frame bits 32..45.
- R4: In a write frame the turnaround bits 46..47 are driven as 1 then 0. The sixteen data bits follow, MSB first. The output enable stays high for all 64 bits.
- R5: In a read frame the output enable is high for bits 0..45 and low for bits 46..63. The input is sampled at each rising management clock edge of bits 48..63, and those samples make up bits 15:0, MSB first.
- R6: The management clock period is CLK_DIV system clock cycles. Each bit spends its first half low and its second half high. The clock and the output enable are both low whenever the block is idle.
- R7: Busy reads 1 from the cycle after an accepted command. It stays 1 for exactly 64*CLK_DIV cycles, and each frame has 64 rising clock edges.
- R8: A register write while busy is ignored. The frame in progress and the stored fields are left unchanged.
- R9: Read-valid reads 0 from the cycle after any accepted command. It reads 1 after a read frame ends and stays 0 after a write frame ends.
- R10: After reset the register reads 0, and the management clock and output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write value (command) |
| regRdData | output | 32 | Register read value (status, fields, data) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data driven value |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data sampled value |

## Verification
The hardest case to reach is a write that lands while busy. It is only visible if the bench proves afterwards that nothing changed, both in the serial frame and in the stored fields. The bench therefore issues a second, different command at a random cycle inside some frames. It then compares all 64 captured bits and the register readback against the first command. A modelled transceiver drives returned data bit by bit on falling clock edges, and read-valid clearing is checked by following reads with writes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_START   = 46;
  localparam int DATA_START = 48;

  typedef struct packed {
    logic load;    // accept a command
    logic shift;   // advance to the next frame bit
    logic sample;  // capture one returned data bit
  } dpCtl_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   regWrEn,
  input  logic   isRead,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   rdValid,
  output logic   mdc,
  output logic   mdioOe
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BW   = $clog2(FRAME_BITS);

  logic [CW-1:0] cnt;
  logic [BW-1:0] bitIdx;
  logic          mdcQ;
  logic          lastTick;
  logic          endFrame;

  always_comb begin
    lastTick   = (cnt == CW'(CLK_DIV - 1));
    endFrame   = busy && lastTick && (bitIdx == BW'(FRAME_BITS - 1));
    ctl.load   = regWrEn && !busy;
    ctl.shift  = busy && lastTick;
    ctl.sample = busy && isRead && (cnt == CW'(HALF - 1)) && (bitIdx >= BW'(DATA_START));
    mdioOe     = busy && !(isRead && (bitIdx >= BW'(TA_START)));
    mdc        = mdcQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      rdValid <= 1'b0;
      cnt     <= '0;
      bitIdx  <= '0;
      mdcQ    <= 1'b0;
    end else if (ctl.load) begin
      busy    <= 1'b1;
      rdValid <= 1'b0;
      cnt     <= '0;
      bitIdx  <= '0;
      mdcQ    <= 1'b0;
    end else if (busy) begin
      cnt <= lastTick ? '0 : cnt + 1'b1;
      if (cnt == CW'(HALF - 1)) mdcQ <= 1'b1;
      else if (lastTick)        mdcQ <= 1'b0;
      if (lastTick) bitIdx <= bitIdx + 1'b1;
      if (endFrame) begin
        busy    <= 1'b0;
        rdValid <= isRead;
      end
    end
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic [31:0] wrData,
  input  logic        mdioIn,
  output logic        frameBit,
  output logic        isRead,
  output logic [10:0] cmdFields,
  output logic [15:0] dataWord
);
  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frameNext;
  logic                  rdOp;

  always_comb begin
    rdOp      = wrData[26];
    frameNext = {32'hFFFF_FFFF, 2'b01,
                 rdOp ? 2'b10 : 2'b01,
                 wrData[20:16], wrData[25:21],
                 rdOp ? 2'b11 : 2'b10,
                 rdOp ? 16'hFFFF : wrData[15:0]};
    frameBit  = shreg[FRAME_BITS-1];
    isRead    = cmdFields[10];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg     <= '1;
      cmdFields <= '0;
      dataWord  <= '0;
    end else if (ctl.load) begin
      shreg     <= frameNext;
      cmdFields <= wrData[26:16];
      dataWord  <= wrData[15:0];
    end else begin
      if (ctl.shift)  shreg    <= {shreg[FRAME_BITS-2:0], 1'b1};
      if (ctl.sample) dataWord <= {dataWord[14:0], mdioIn};
    end
  end
endmodule

// File: rtl/mdio_cmd_ctl.sv
module mdio_cmd_ctl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  dpCtl_t      ctl;
  logic        busy;
  logic        rdValid;
  logic        isRead;
  logic [10:0] cmdFields;
  logic [15:0] dataWord;

  mdio_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .isRead(isRead),
    .ctl(ctl), .busy(busy), .rdValid(rdValid), .mdc(mdc), .mdioOe(mdioOe)
  );

  mdio_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(regWrData), .mdioIn(mdioIn),
    .frameBit(mdioOut), .isRead(isRead), .cmdFields(cmdFields), .dataWord(dataWord)
  );

  assign regRdData = {3'b000, busy, rdValid, cmdFields, dataWord};
endmodule

// File: rtl/mdio_cmd_chk.sv
module mdio_cmd_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [31:0] regRdData,
  input logic        mdc,
  input logic        mdioOe
);
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[28] |-> !mdc); // R6
  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[28] |-> !mdioOe); // R6
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[28] && !regRdData[26]) |-> mdioOe); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[28] && regWrEn) |=> $stable(regRdData[26:16])); // R8
  AST_ACCEPT_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[28] && regWrEn) |=> (regRdData[28] && !regRdData[27])); // R9
  AST_NO_VALID_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[28] |-> !regRdData[27]); // R9
  AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[31:29] == 3'b000); // R1
endmodule

bind mdio_cmd_ctl mdio_cmd_chk u_chk (.*);

// File: tb/sim_mdio_cmd_ctl.sv
module sim_mdio_cmd_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int total = 0;
  int bad = 0;
  int riseCnt = 0;
  int periodErr = 0;
  realtime lastRise = 0;
  logic [63:0] capOut, capOe;
  logic [15:0] phyData = '0;

  mdio_cmd_ctl #(.CLK_DIV(DIV)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // transceiver model: record each rising edge, drive read data after falling edges
  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      capOut[63-riseCnt] = mdioOut;
      capOe[63-riseCnt]  = mdioOe;
    end
    if (riseCnt > 0 && ($realtime - lastRise) != DIV * CLK_PERIOD) periodErr++;
    lastRise = $realtime;
    riseCnt++;
  end

  always @(negedge mdc) begin
    if (riseCnt >= 48 && riseCnt < 64) mdioIn = phyData[15-(riseCnt-48)];
    else mdioIn = 1'b1;
  end

  function automatic logic [63:0] expFrame(input logic rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] f;
    f = '1;
    f[31:30] = 2'b01;
    f[29:28] = rd ? 2'b10 : 2'b01;
    f[27:23] = phy;
    f[22:18] = rg;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  function automatic logic [63:0] expOe(input logic rd);
    return rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : '1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doCmd(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] d, input int ignAt);
    logic [31:0] cmd;
    logic [63:0] ef, eo;
    int cyc;
    cmd = {5'b0, rd, rg, phy, d};
    phyData = $urandom;
    riseCnt = 0;
    periodErr = 0;
    @(negedge clk); regWrEn = 1'b1; regWrData = cmd;
    @(negedge clk); regWrEn = 1'b0; regWrData = ~cmd;
    chk(regRdData[28] == 1'b1, "R7 busy after accept", 64'(regRdData[28]), 64'd1);
    chk(regRdData[27] == 1'b0, "R9 valid cleared", 64'(regRdData[27]), 64'd0);
    chk(regRdData[26:16] == cmd[26:16], "R1 fields readback", 64'(regRdData[26:16]), 64'(cmd[26:16]));
    cyc = 0;
    while (regRdData[28] && cyc < 100000) begin
      cyc++;
      if (cyc == ignAt) regWrEn = 1'b1;   // R8 write while busy
      else regWrEn = 1'b0;
      @(negedge clk);
    end
    regWrEn = 1'b0;
    chk(cyc == 64 * DIV, "R7 busy length", 64'(cyc), 64'(64 * DIV));
    chk(riseCnt == 64, "R7 edge count", 64'(riseCnt), 64'd64);
    chk(periodErr == 0, "R6 clock period", 64'(periodErr), 64'd0);
    ef = expFrame(rd, phy, rg, d);
    eo = expOe(rd);
    chk(capOe == eo, rd ? "R5 oe pattern" : "R4 oe pattern", capOe, eo);
    chk(capOut[63:30] == ef[63:30], "R2 preamble/start", capOut, ef);
    chk(capOut[29:18] == ef[29:18], "R3 opcode/addresses", 64'(capOut[29:18]), 64'(ef[29:18]));
    if (!rd) chk(capOut[17:0] == ef[17:0], "R4 turnaround/data", 64'(capOut[17:0]), 64'(ef[17:0]));
    chk(regRdData[26:16] == cmd[26:16], "R8 fields kept", 64'(regRdData[26:16]), 64'(cmd[26:16]));
    chk(regRdData[27] == rd, "R9 valid at end", 64'(regRdData[27]), 64'(rd));
    if (rd) chk(regRdData[15:0] == phyData, "R5 read data", 64'(regRdData[15:0]), 64'(phyData));
    else    chk(regRdData[15:0] == d, "R1 write data readback", 64'(regRdData[15:0]), 64'(d));
    repeat (3) @(negedge clk);
    chk(mdc == 1'b0 && mdioOe == 1'b0, "R6 idle low", {62'b0, mdc, mdioOe}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(regRdData == 32'h0, "R10 reset register", 64'(regRdData), 64'd0);
    chk(mdc == 1'b0 && mdioOe == 1'b0, "R10 reset pins", {62'b0, mdc, mdioOe}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    doCmd(1'b0, 5'd31, 5'd31, 16'hFFFF, 0);
    doCmd(1'b1, 5'd0, 5'd0, 16'h0000, 0);
    doCmd(1'b0, 5'd5, 5'd17, 16'hA5C3, 37);  // R9 write after read, R8 ignored write
    doCmd(1'b1, 5'd18, 5'd9, 16'h1234, 64 * DIV);  // R8 ignored write in last busy cycle
    for (int i = 0; i < 12; i++) begin
      int ign;
      ign = (($urandom % 3) == 0) ? int'(1 + ($urandom % (64 * DIV - 1))) : 0;
      doCmd(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), ign);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule